// File: doc/BRIEF.md
# Level-Qualified Input Event Latch with Interrupt Steering

This block watches a bank of general-purpose input lines and records each one's activity in a sticky status bit that only software can clear. Each line has its own polarity bit that chooses whether a high or a low level counts as active. The inputs are sampled only when a sample strobe fires. A rate-select input picks either a fast strobe, used in the working power states, or a slow real-time strobe, used in the sleep states. Every line except line 0 needs two back-to-back active samples before its status bit sets. Line 0 sets on a single active sample.

Each line also has a two-bit steering field. The field sends the line's status to the system-management request, to the configuration-interrupt request, or to neither. No encoding sends a line to both. The status bits are level-sensitive. If software clears a bit while the qualified input is still active, the bit sets again on the next sample without a new edge. A small register port lets software read status, polarity and steering, write polarity and steering, and clear status bits by writing ones.

Top module: `gpi_event_router`

## Requirements
- R1: A synchronous active-high reset clears all status, polarity and steering bits and drives smi_req and sci_req to 0.
- R2: A line i with i >= 1 sets status bit i only after its qualified input is active on two consecutive samples. A single active sample leaves the bit at 0.
- R3: Line 0 sets status bit 0 on a single active sample.
- R4: The qualified input is sense_in[i] XOR polarity bit i. With the polarity bit at 1, a low input is active.
- R5: A set status bit stays set while the input is inactive. It clears only when software writes a 1 to that bit at address 0. Writing 0s leaves it unchanged.
- R6: If status bit i is cleared while the qualified input is still active, the bit sets again at the next sample strobe without a new edge.
- R7: When a clear-write and a qualifying set event for the same bit occur in the same cycle, the bit ends up set.
- R8: With rate_sel = 0, sampling happens only on fast_tick. With rate_sel = 1, it happens only on slow_tick. The strobe that is not selected has no effect.
- R9: A change of rate_sel discards the filter history. A sample taken at the old rate cannot combine with a sample at the new rate to qualify a line i >= 1.
- R10: Steering field i is held in bits [2i+1:2i] of address 2, with 01 = SMI, 10 = SCI, and 00 or 11 = neither. smi_req is the OR of the status bits steered to SMI, and sci_req is the OR of those steered to SCI. Each output is registered and follows status with a delay of one cycle.
- R11: Address 0 reads status (bit i = line i). Address 1 reads and writes polarity (bit i = line i). Address 2 reads and writes steering. Address 3 reads as 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_in | input | N_LINES | Raw input lines, synchronous to clk |
| fast_tick | input | 1 | Fast sample strobe, one cycle wide |
| slow_tick | input | 1 | Slow sample strobe, one cycle wide |
| rate_sel | input | 1 | 0 selects fast_tick, 1 selects slow_tick |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2*N_LINES | Register write data |
| reg_rdata | output | 2*N_LINES | Register read data |
| smi_req | output | 1 | System-management request |
| sci_req | output | 1 | Configuration-interrupt request |

## Verification
The bench uses the default N_LINES = 16. At that width the steering word fills the whole 32-bit register, so the top line's field at bits 31:30 and the register boundaries can be reached. Both strobes are bench-driven ports, so slow-rate sampling and a rate change in the same cycle as a strobe take only a few cycles to exercise. The checks also cover single versus double samples, a clear racing a set, and the reserved steering code.

// File: rtl/gpi_evt_pkg.sv
package gpi_evt_pkg;

    typedef enum logic [1:0] {
        RT_NONE = 2'b00,
        RT_SMI  = 2'b01,
        RT_SCI  = 2'b10,
        RT_RSVD = 2'b11
    } route_e;

    localparam logic [1:0] ADDR_STAT  = 2'd0;
    localparam logic [1:0] ADDR_POL   = 2'd1;
    localparam logic [1:0] ADDR_ROUTE = 2'd2;

    typedef struct packed {
        logic smi;
        logic sci;
    } steer_t;

    // Reserved code maps to no destination, so both is never produced.
    function automatic steer_t decode_route(input logic [1:0] f);
        steer_t s;
        s = '0;
        case (route_e'(f))
            RT_SMI:  s.smi = 1'b1;
            RT_SCI:  s.sci = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpi_cfg_regs.sv
module gpi_cfg_regs
    import gpi_evt_pkg::*;
#(
    parameter int N_LINES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             addr,
    input  logic [2*N_LINES-1:0]   wdata,
    input  logic [N_LINES-1:0]     status_q,
    output logic [N_LINES-1:0]     pol_q,
    output logic [2*N_LINES-1:0]   route_q,
    output logic [N_LINES-1:0]     clr_mask,
    output logic [2*N_LINES-1:0]   rdata
);
    localparam int DW = 2 * N_LINES;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q   <= '0;
            route_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_POL)   pol_q   <= wdata[N_LINES-1:0];
            if (addr == ADDR_ROUTE) route_q <= wdata;
        end
    end

    always_comb begin
        clr_mask = '0;
        if (wr_en && addr == ADDR_STAT) clr_mask = wdata[N_LINES-1:0];
    end

    always_comb begin
        case (addr)
            ADDR_STAT:  rdata = {{(DW-N_LINES){1'b0}}, status_q};
            ADDR_POL:   rdata = {{(DW-N_LINES){1'b0}}, pol_q};
            ADDR_ROUTE: rdata = route_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpi_qual_filter.sv
module gpi_qual_filter #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] sense_in,
    input  logic [N_LINES-1:0] pol_q,
    input  logic               fast_tick,
    input  logic               slow_tick,
    input  logic               rate_sel,
    output logic [N_LINES-1:0] set_evt
);
    logic               rate_q;
    logic               rate_chg;
    logic               smp;
    logic [N_LINES-1:0] qual;

    assign rate_chg = rate_sel ^ rate_q;
    assign smp      = rate_sel ? slow_tick : fast_tick;
    assign qual     = sense_in ^ pol_q;

    always_ff @(posedge clk) begin
        if (rst) rate_q <= 1'b0;
        else     rate_q <= rate_sel;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        if (i == 0) begin : g_direct
            // Unfiltered line: one active sample is enough.
            assign set_evt[i] = smp & qual[i];
        end else begin : g_two_sample
            logic hist_q;
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= 1'b0;
                else if (rate_chg) hist_q <= smp & qual[i];
                else if (smp)      hist_q <= qual[i];
            end
            // Old-rate history is masked on the cycle the rate changes.
            assign set_evt[i] = smp & qual[i] & hist_q & ~rate_chg;
        end
    end
endmodule

// File: rtl/gpi_status_bank.sv
module gpi_status_bank #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] set_evt,
    input  logic [N_LINES-1:0] clr_mask,
    output logic [N_LINES-1:0] status_q
);
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | set_evt;
    end
endmodule

// File: rtl/gpi_route_merge.sv
module gpi_route_merge
    import gpi_evt_pkg::*;
#(
    parameter int N_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_LINES-1:0]   status_q,
    input  logic [2*N_LINES-1:0] route_q,
    output logic                 smi_req,
    output logic                 sci_req
);
    logic [N_LINES-1:0] to_smi;
    logic [N_LINES-1:0] to_sci;

    for (genvar i = 0; i < N_LINES; i++) begin : g_dec
        steer_t st;
        assign st        = decode_route(route_q[2*i +: 2]);
        assign to_smi[i] = status_q[i] & st.smi;
        assign to_sci[i] = status_q[i] & st.sci;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_req <= 1'b0;
            sci_req <= 1'b0;
        end else begin
            smi_req <= |to_smi;
            sci_req <= |to_sci;
        end
    end
endmodule

// File: rtl/gpi_event_router.sv
module gpi_event_router #(
    parameter int N_LINES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_LINES-1:0]     sense_in,
    input  logic                   fast_tick,
    input  logic                   slow_tick,
    input  logic                   rate_sel,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [2*N_LINES-1:0]   reg_wdata,
    output logic [2*N_LINES-1:0]   reg_rdata,
    output logic                   smi_req,
    output logic                   sci_req
);
    logic [N_LINES-1:0]   pol_q;
    logic [2*N_LINES-1:0] route_q;
    logic [N_LINES-1:0]   clr_mask;
    logic [N_LINES-1:0]   set_evt;
    logic [N_LINES-1:0]   status_q;

    gpi_cfg_regs #(.N_LINES(N_LINES)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .status_q (status_q),
        .pol_q    (pol_q),
        .route_q  (route_q),
        .clr_mask (clr_mask),
        .rdata    (reg_rdata)
    );

    gpi_qual_filter #(.N_LINES(N_LINES)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .sense_in  (sense_in),
        .pol_q     (pol_q),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .rate_sel  (rate_sel),
        .set_evt   (set_evt)
    );

    gpi_status_bank #(.N_LINES(N_LINES)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (set_evt),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    gpi_route_merge #(.N_LINES(N_LINES)) u_route (
        .clk      (clk),
        .rst      (rst),
        .status_q (status_q),
        .route_q  (route_q),
        .smi_req  (smi_req),
        .sci_req  (sci_req)
    );
endmodule

// File: rtl/gpi_event_router_chk.sv
module gpi_event_router_chk #(
    parameter int N_LINES = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_LINES-1:0]     sense_in,
    input logic [N_LINES-1:0]     pol_q,
    input logic [2*N_LINES-1:0]   route_q,
    input logic                   fast_tick,
    input logic                   slow_tick,
    input logic                   rate_sel,
    input logic                   reg_we,
    input logic [1:0]             reg_addr,
    input logic [2*N_LINES-1:0]   reg_wdata,
    input logic [N_LINES-1:0]     status_q,
    input logic                   smi_req,
    input logic                   sci_req
);
    logic [N_LINES-1:0] wclr;
    logic [N_LINES-1:0] keep;
    logic [N_LINES-1:0] act;
    logic               sel_tick;
    logic               want_smi;
    logic               want_sci;

    always_comb begin
        wclr     = (reg_we && reg_addr == 2'd0) ? reg_wdata[N_LINES-1:0] : '0;
        keep     = status_q & ~wclr;
        act      = sense_in ^ pol_q;
        sel_tick = rate_sel ? slow_tick : fast_tick;
        want_smi = 1'b0;
        want_sci = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (route_q[2*i +: 2] == 2'b01 && status_q[i]) want_smi = 1'b1;
            if (route_q[2*i +: 2] == 2'b10 && status_q[i]) want_sci = 1'b1;
        end
    end

    // R1: reset empties status and quiets both requests
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (status_q == '0 && !smi_req && !sci_req));

    // R5: bits not cleared by a write remain set
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(keep)) == $past(keep)));

    // R8: no new status bit without the selected strobe
    a_r8_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !sel_tick |=> ((status_q & ~$past(status_q)) == '0));

    // R4: a new status bit needs its qualified input active
    a_r4_needs_active: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(act)) == '0));

    // R10: requests follow steered status one cycle later
    a_r10_smi_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (smi_req == $past(want_smi)));

    a_r10_sci_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sci_req == $past(want_sci)));
endmodule

bind gpi_event_router gpi_event_router_chk #(.N_LINES(N_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sense_in  (sense_in),
    .pol_q     (pol_q),
    .route_q   (route_q),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .rate_sel  (rate_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .status_q  (status_q),
    .smi_req   (smi_req),
    .sci_req   (sci_req)
);

// File: tb/gpi_event_router_bench.sv
module gpi_event_router_bench;
    localparam int N  = 16;
    localparam int DW = 2 * N;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  sense_in;
    logic          fast_tick, slow_tick, rate_sel;
    logic          reg_we;
    logic [1:0]    reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic          smi_req, sci_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpi_event_router #(.N_LINES(N)) u_gpi_event_router (
        .clk(clk), .rst(rst), .sense_in(sense_in),
        .fast_tick(fast_tick), .slow_tick(slow_tick), .rate_sel(rate_sel),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .smi_req(smi_req), .sci_req(sci_req)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 2'd0;
    endtask

    task automatic tick_fast();
        @(negedge clk); fast_tick = 1'b1;
        @(negedge clk); fast_tick = 1'b0;
    endtask

    task automatic tick_slow();
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
    endtask

    task automatic cleanup();
        @(negedge clk);
        sense_in = '0; rate_sel = 1'b0;
        wr(2'd1, '0);
        wr(2'd2, '0);
        tick_fast(); tick_fast();
        wr(2'd0, {DW{1'b1}});
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        rd(2'd0, d); check("R1 status", d, '0);
        rd(2'd1, d); check("R1 polarity", d, '0);
        rd(2'd2, d); check("R1 steering", d, '0);
        check("R1 smi", DW'(smi_req), '0);
        check("R1 sci", DW'(sci_req), '0);
    endtask

    task automatic t_filter();
        logic [DW-1:0] d;
        sense_in[5] = 1'b1;
        tick_fast(); rd(2'd0, d); check("R2 one sample", d, '0);
        tick_fast(); rd(2'd0, d); check("R2 two samples", d, DW'(1 << 5));
        cleanup();
    endtask

    task automatic t_line0();
        logic [DW-1:0] d;
        sense_in[0] = 1'b1;
        tick_fast(); rd(2'd0, d); check("R3 single sample", d, 32'h1);
        cleanup();
    endtask

    task automatic t_polarity();
        logic [DW-1:0] d;
        wr(2'd1, DW'(1 << 3));
        tick_fast(); tick_fast();
        rd(2'd0, d); check("R4 low active", d, DW'(1 << 3));
        cleanup();
    endtask

    task automatic t_sticky();
        logic [DW-1:0] d;
        sense_in[7] = 1'b1; tick_fast(); tick_fast();
        sense_in[7] = 1'b0; tick_fast(); tick_fast(); tick_fast();
        rd(2'd0, d); check("R5 held", d, DW'(1 << 7));
        wr(2'd0, ~DW'(1 << 7));
        rd(2'd0, d); check("R5 zero write", d, DW'(1 << 7));
        wr(2'd0, DW'(1 << 7));
        rd(2'd0, d); check("R5 cleared", d, '0);
        cleanup();
    endtask

    task automatic t_rearm();
        logic [DW-1:0] d;
        sense_in[9] = 1'b1; tick_fast(); tick_fast();
        wr(2'd0, DW'(1 << 9));
        rd(2'd0, d); check("R6 after clear", d, '0);
        tick_fast();
        rd(2'd0, d); check("R6 re-set", d, DW'(1 << 9));
        cleanup();
    endtask

    task automatic t_setwins();
        logic [DW-1:0] d;
        sense_in[0] = 1'b1; tick_fast();
        @(negedge clk);
        fast_tick = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1;
        @(negedge clk);
        fast_tick = 1'b0; reg_we = 1'b0;
        rd(2'd0, d); check("R7 set wins", d, 32'h1);
        cleanup();
    endtask

    task automatic t_strobe_sel();
        logic [DW-1:0] d;
        @(negedge clk); rate_sel = 1'b1; sense_in[4] = 1'b1;
        tick_fast(); tick_fast(); tick_fast();
        rd(2'd0, d); check("R8 fast ignored", d, '0);
        tick_slow(); tick_slow();
        rd(2'd0, d); check("R8 slow samples", d, DW'(1 << 4));
        cleanup();
        sense_in[4] = 1'b1;
        tick_slow(); tick_slow();
        rd(2'd0, d); check("R8 slow ignored", d, '0);
        cleanup();
    endtask

    task automatic t_ratechg();
        logic [DW-1:0] d;
        sense_in[6] = 1'b1; tick_fast();
        @(negedge clk); rate_sel = 1'b1; slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
        rd(2'd0, d); check("R9 no mixed qualify", d, '0);
        tick_slow();
        rd(2'd0, d); check("R9 new rate qualifies", d, DW'(1 << 6));
        cleanup();
    endtask

    task automatic t_route();
        logic [DW-1:0] d;
        wr(2'd2, 32'hC00000E4);
        sense_in[3] = 1'b1; sense_in[15] = 1'b1;
        tick_fast(); tick_fast(); @(negedge clk);
        check("R10 reserved smi", DW'(smi_req), '0);
        check("R10 reserved sci", DW'(sci_req), '0);
        sense_in[3] = 1'b0; sense_in[15] = 1'b0;
        sense_in[1] = 1'b1;
        tick_fast(); tick_fast();
        check("R10 smi not yet", DW'(smi_req), '0);
        @(negedge clk);
        check("R10 smi one later", DW'(smi_req), 32'h1);
        check("R10 sci quiet", DW'(sci_req), '0);
        sense_in[1] = 1'b0; sense_in[2] = 1'b1;
        tick_fast(); tick_fast(); @(negedge clk);
        check("R10 sci", DW'(sci_req), 32'h1);
        sense_in[2] = 1'b0;
        wr(2'd0, DW'(1 << 1));
        @(negedge clk);
        check("R10 smi drops", DW'(smi_req), '0);
        rd(2'd2, d); check("R11 steering readback", d, 32'hC00000E4);
        cleanup();
    endtask

    task automatic t_regmap();
        logic [DW-1:0] d;
        wr(2'd1, 32'hFFFFA5A5);
        rd(2'd1, d); check("R11 polarity width", d, 32'h0000A5A5);
        rd(2'd3, d); check("R11 addr3 zero", d, '0);
        wr(2'd1, '0);
        tick_fast(); tick_fast();
        wr(2'd0, {DW{1'b1}});
    endtask

    initial begin
        rst = 1'b1; sense_in = '0; fast_tick = 1'b0; slow_tick = 1'b0;
        rate_sel = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_filter();
        t_line0();
        t_polarity();
        t_sticky();
        t_rearm();
        t_setwins();
        t_strobe_sel();
        t_ratechg();
        t_route();
        t_regmap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule